// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer

This block sits on the host side of a 16-bit successive-approximation converter that is reached over a three- or four-wire serial link. When a start request is accepted, the sequencer drives the convert strobe high and holds it there for a programmable number of system-clock cycles, which covers the conversion time. It then drops the strobe. This enables the converter's data output and opens the readout window. The sequencer generates exactly one word's worth of shift clocks from a divided system clock and collects the result most significant bit first.

While the result comes in, the sequencer sends a 2-bit configuration word on its data-out line. The converter uses that word for the conversion that follows. A higher-level controller sees a simple interface: a start pulse with a mode value, a busy flag, and a result that appears together with a one-cycle valid pulse. The configuration word has two fields. Its upper bit picks single-ended (1) or differential (0) input. Its lower bit picks the input channel in single-ended mode, or the pair polarity in differential mode.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While reset is asserted and right after it, the convert strobe, shift clock, configuration line, busy, valid and the result are all zero.
- R2: If start_i is high at a clock edge while the block is idle, conv_o and busy_o are high after that edge, and conv_o then stays high for exactly CONV_CYCLES cycles.
- R3: The first shift-clock rising edge comes SETUP_CYCLES + HALF_DIV cycles after conv_o falls.
- R4: Each readout has exactly DATA_BITS shift-clock pulses, and every high and low phase inside the burst lasts HALF_DIV cycles.
- R5: sdo_i is sampled at each shift-clock rising edge, and the first sample is the most significant bit. The assembled word appears on result_o when valid_o is high.
- R6: mode_i is latched when a start is accepted. cfg_o carries the latched mode bit 1 at the first shift-clock rising edge and bit 0 at the second, and is zero at later edges. cfg_o only changes while the shift clock is low.
- R7: After the last shift-clock falling edge, conv_o stays low for HOLD_CYCLES cycles. Then valid_o is high for exactly one cycle, and busy_o is low in that same cycle. busy_o stays high from acceptance until then.
- R8: A start that arrives while busy_o is high has no effect. It does not start a new conversion and does not change the latched mode. A start that is held through the valid cycle is accepted at once.
- R9: The shift clock is never high while conv_o is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to run one conversion and readout |
| mode_i | input | CFG_BITS | Configuration word sent during this readout |
| sdo_i | input | 1 | Serial result bit from the converter |
| conv_o | output | 1 | Convert strobe: high converts, low reads out |
| sclk_o | output | 1 | Shift clock to the converter |
| cfg_o | output | 1 | Serial configuration bit to the converter |
| result_o | output | DATA_BITS | Last assembled conversion result |
| valid_o | output | 1 | One-cycle pulse marking a new result |
| busy_o | output | 1 | High from acceptance until the result is valid |

## Verification
The hardest case to reach is a start request that lands on the last busy cycle, when the hold timer runs out. The same case with the request held over into the valid cycle must be accepted on the very next edge. The stimulus counts cycles from acceptance so that it can place a one-cycle request exactly there. It also holds start_i high across several back-to-back transactions. The configuration handoff is checked end to end: each mode is fed back through a converter model that applies it only to the next conversion. A wrong bit order or a late configuration bit therefore shows up as a wrong result one transaction later.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    // Phases of one conversion/readout transaction.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_CONVERT = 3'd1,
        ST_SETUP   = 3'd2,
        ST_SHIFT   = 3'd3,
        ST_HOLD    = 3'd4
    } seq_state_e;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/seq_timer.sv
// Loadable down-counter; expired_o is high while the count rests at zero.
module seq_timer #(
    parameter int unsigned WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] value_i,
    output logic             expired_o
);
    logic [WIDTH-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (load_i) begin
            count_d = value_i;
        end else if (count_q != '0) begin
            count_d = count_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign expired_o = (count_q == '0);
endmodule

// File: rtl/sclk_divider.sv
// Emits a one-cycle tick every HALF_DIV cycles while enabled; restarts on enable.
module sclk_divider #(
    parameter int unsigned HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    generate
        if (HALF_DIV <= 1) begin : g_direct
            assign tick_o = en_i;
        end else begin : g_count
            localparam int unsigned CW = $clog2(HALF_DIV);
            localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);
            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                if (!en_i)             cnt_d = '0;
                else if (cnt_q == LAST) cnt_d = '0;
                else                    cnt_d = cnt_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign tick_o = en_i && (cnt_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/rx_shifter.sv
// Left-shifting capture register: first bit in ends up as the MSB.
module rx_shifter #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             shift_i,
    input  logic             bit_i,
    output logic [WIDTH-1:0] word_o
);
    logic [WIDTH-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (clear_i)      word_d = '0;
        else if (shift_i) word_d = {word_q[WIDTH-2:0], bit_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign word_o = word_q;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int unsigned DATA_BITS    = 16,
    parameter int unsigned CFG_BITS     = 2,
    parameter int unsigned HALF_DIV     = 4,
    parameter int unsigned CONV_CYCLES  = 400,
    parameter int unsigned SETUP_CYCLES = 4,
    parameter int unsigned HOLD_CYCLES  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [CFG_BITS-1:0]  mode_i,
    input  logic                 sdo_i,
    output logic                 conv_o,
    output logic                 sclk_o,
    output logic                 cfg_o,
    output logic [DATA_BITS-1:0] result_o,
    output logic                 valid_o,
    output logic                 busy_o
);
    localparam int unsigned LONGEST = max3(CONV_CYCLES, SETUP_CYCLES, HOLD_CYCLES);
    localparam int unsigned TW      = $clog2(LONGEST + 1);
    localparam int unsigned BW      = $clog2(DATA_BITS + 1);
    localparam logic [TW-1:0] T_CONV  = TW'(CONV_CYCLES - 1);
    localparam logic [TW-1:0] T_SETUP = TW'(SETUP_CYCLES - 1);
    localparam logic [TW-1:0] T_HOLD  = TW'(HOLD_CYCLES - 1);
    localparam logic [BW-1:0] LAST_BIT = BW'(DATA_BITS);

    typedef struct packed {
        seq_state_e           state;
        logic                 conv;
        logic                 sclk;
        logic                 sdi;
        logic [CFG_BITS-1:0]  cfg;
        logic [BW-1:0]        bits;
        logic [DATA_BITS-1:0] result;
        logic                 valid;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;

    logic                 tmr_load;
    logic [TW-1:0]        tmr_value;
    logic                 tmr_expired;
    logic                 half_tick;
    logic                 shift_en;
    logic                 shift_clear;
    logic [DATA_BITS-1:0] shift_word;
    logic [CFG_BITS-1:0]  cfg_aligned;

    seq_timer #(.WIDTH(TW)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .value_i   (tmr_value),
        .expired_o (tmr_expired)
    );

    sclk_divider #(.HALF_DIV(HALF_DIV)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (seq_q.state == ST_SHIFT),
        .tick_o (half_tick)
    );

    rx_shifter #(.WIDTH(DATA_BITS)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (shift_clear),
        .shift_i (shift_en),
        .bit_i   (sdo_i),
        .word_o  (shift_word)
    );

    always_comb begin
        seq_d       = seq_q;
        seq_d.valid = 1'b0;
        tmr_load    = 1'b0;
        tmr_value   = '0;
        shift_en    = 1'b0;
        shift_clear = 1'b0;
        // Configuration bit due next: the MSB of the latched word after
        // discarding the bits already clocked out.
        cfg_aligned = seq_q.cfg << seq_q.bits;

        unique case (seq_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    seq_d.state = ST_CONVERT;
                    seq_d.conv  = 1'b1;
                    seq_d.cfg   = mode_i;
                    seq_d.bits  = '0;
                    tmr_load    = 1'b1;
                    tmr_value   = T_CONV;
                end
            end
            ST_CONVERT: begin
                if (tmr_expired) begin
                    seq_d.state = ST_SETUP;
                    seq_d.conv  = 1'b0;
                    seq_d.sdi   = cfg_aligned[CFG_BITS-1];
                    shift_clear = 1'b1;
                    tmr_load    = 1'b1;
                    tmr_value   = T_SETUP;
                end
            end
            ST_SETUP: begin
                if (tmr_expired) seq_d.state = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (half_tick) begin
                    if (!seq_q.sclk) begin
                        seq_d.sclk = 1'b1;
                        seq_d.bits = seq_q.bits + 1'b1;
                        shift_en   = 1'b1;
                    end else begin
                        seq_d.sclk = 1'b0;
                        seq_d.sdi  = cfg_aligned[CFG_BITS-1];
                        if (seq_q.bits == LAST_BIT) begin
                            seq_d.state = ST_HOLD;
                            tmr_load    = 1'b1;
                            tmr_value   = T_HOLD;
                        end
                    end
                end
            end
            ST_HOLD: begin
                if (tmr_expired) begin
                    seq_d.state  = ST_IDLE;
                    seq_d.valid  = 1'b1;
                    seq_d.result = shift_word;
                end
            end
            default: seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: ST_IDLE, conv: 1'b0, sclk: 1'b0, sdi: 1'b0,
                       cfg: '0, bits: '0, result: '0, valid: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign conv_o   = seq_q.conv;
    assign sclk_o   = seq_q.sclk;
    assign cfg_o    = seq_q.sdi;
    assign result_o = seq_q.result;
    assign valid_o  = seq_q.valid;
    assign busy_o   = (seq_q.state != ST_IDLE);
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
    parameter int unsigned DATA_BITS = 16,
    parameter int unsigned HALF_DIV  = 4
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic conv_o,
    input logic sclk_o,
    input logic cfg_o,
    input logic valid_o,
    input logic busy_o
);
    int unsigned high_run;
    int unsigned rise_seen;
    logic        sclk_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            high_run  <= 0;
            rise_seen <= 0;
            sclk_prev <= 1'b0;
        end else begin
            sclk_prev <= sclk_o;
            high_run  <= sclk_o ? high_run + 1 : 0;
            if (conv_o)                     rise_seen <= 0;
            else if (sclk_o && !sclk_prev)  rise_seen <= rise_seen + 1;
        end
    end

    assert_sclk_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        conv_o |-> !sclk_o);

    assert_high_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk_o) |-> (high_run == HALF_DIV));

    assert_pulse_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (rise_seen == DATA_BITS));

    assert_cfg_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(cfg_o));

    assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    assert_valid_ends_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (!busy_o && $past(busy_o)));

    assert_conv_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_o) |-> busy_o);

    assert_busy_ignores_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> !$rose(conv_o));
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(
    .DATA_BITS (DATA_BITS),
    .HALF_DIV  (HALF_DIV)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .conv_o  (conv_o),
    .sclk_o  (sclk_o),
    .cfg_o   (cfg_o),
    .valid_o (valid_o),
    .busy_o  (busy_o)
);

// File: tb/adc_seq_ctrl_tb.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb;
    localparam int DB = 16;
    localparam int NC = 400;
    localparam int SU = 4;
    localparam int HD = 4;
    localparam int HO = 2;
    localparam int SS = NC + SU + 1;
    localparam int LL = SS + 2 * DB * HD + HO;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        sdo = 1'b0;
    logic        conv_w, sclk_w, cfg_w, valid_w, busy_w;
    logic [15:0] result_w;

    always #4 clk = ~clk;

    adc_seq_ctrl #(
        .DATA_BITS(DB), .CFG_BITS(2), .HALF_DIV(HD),
        .CONV_CYCLES(NC), .SETUP_CYCLES(SU), .HOLD_CYCLES(HO)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode), .sdo_i(sdo),
        .conv_o(conv_w), .sclk_o(sclk_w), .cfg_o(cfg_w), .result_o(result_w),
        .valid_o(valid_w), .busy_o(busy_w)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] sample_of(input int n, input logic [1:0] c);
        logic [15:0] base;
        case (n)
            0: base = 16'h0000;
            1: base = 16'hFFFF;
            2: base = 16'h8001;
            3: base = 16'hA5C3;
            default: base = 16'(n * 32'h9E37 + 32'h1234);
        endcase
        return base ^ {c, 14'b0};
    endfunction

    // Behavioural converter: config captured in a readout applies to the next conversion.
    logic [15:0] adc_word = 16'h0;
    logic [1:0]  adc_cfg_next = 2'b10;
    logic [1:0]  cap_word = 2'b00;
    int          adc_idx = 0;
    int          adc_pos = 15;
    int          adc_rises = 0;
    logic [1:0]  exp_mode_cur = 2'b00;

    always @(posedge conv_w) begin
        adc_word = sample_of(adc_idx, adc_cfg_next);
        adc_idx++;
    end

    always @(negedge conv_w) begin
        adc_rises = 0;
        adc_pos   = 15;
        sdo       = adc_word[15];
    end

    always @(posedge sclk_w) begin
        if (rst_n && !conv_w) begin
            if (adc_rises == 0) cap_word[1] = cfg_w;
            else if (adc_rises == 1) cap_word[0] = cfg_w;
            adc_rises++;
            if (adc_rises == 2) begin
                adc_cfg_next = cap_word;
                chk("R6", 32'(cap_word), 32'(exp_mode_cur), "config word seen by converter");
            end
        end
    end

    always @(negedge sclk_w) begin
        if (rst_n && !conv_w) begin
            adc_pos--;
            sdo = (adc_pos >= 0) ? adc_word[adc_pos] : 1'b0;
        end
    end

    // Cycle reference model of the sequencer timing.
    bit          act = 1'b0;
    int          r = 0;
    int          acc_cnt = 0;
    logic [1:0]  prev_mode = 2'b10;
    logic [15:0] expq[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            act = 1'b0;
            r   = 0;
        end else if (act && r < LL) begin
            r++;
        end else if (start) begin
            act = 1'b1;
            r   = 1;
            expq.push_back(sample_of(acc_cnt, prev_mode));
            exp_mode_cur = mode;
            prev_mode    = mode;
            acc_cnt++;
        end else begin
            act = 1'b0;
        end
    end

    bit   run_cmp = 1'b0;
    logic prev_conv = 1'b0;
    logic prev_sclk = 1'b0;
    int   since_conv_fall = 0;
    int   since_sclk_fall = 0;
    int   rises_obs = 0;
    int   conv_rises = 0;
    bit   first_rise = 1'b0;

    always @(negedge clk) begin
        if (run_cmp) begin
            logic e_conv, e_sclk, e_busy, e_valid;
            logic [15:0] e_res;
            e_conv  = act && r >= 1 && r <= NC;
            e_sclk  = act && r >= SS + HD && r < SS + 2 * DB * HD
                      && (((r - SS - HD) % (2 * HD)) < HD);
            e_busy  = act && r < LL;
            e_valid = act && r == LL;
            chk("R2", 32'(conv_w), 32'(e_conv), "conv_o");
            chk("R4", 32'(sclk_w), 32'(e_sclk), "sclk_o");
            chk("R7", 32'(busy_w), 32'(e_busy), "busy_o");
            chk("R7", 32'(valid_w), 32'(e_valid), "valid_o");
            chk("R9", 32'(conv_w & sclk_w), 32'd0, "sclk high during conversion");

            if (!prev_conv && conv_w) begin
                conv_rises++;
                rises_obs = 0;
            end
            if (prev_conv && !conv_w) begin
                since_conv_fall = 0;
                first_rise      = 1'b1;
            end else begin
                since_conv_fall++;
            end
            if (!prev_sclk && sclk_w) begin
                rises_obs++;
                if (first_rise) begin
                    chk("R3", 32'(since_conv_fall), 32'(SU + HD), "strobe-low to first rise");
                    first_rise = 1'b0;
                end
            end
            if (prev_sclk && !sclk_w) since_sclk_fall = 0;
            else since_sclk_fall++;

            if (valid_w) begin
                e_res = (expq.size() > 0) ? expq.pop_front() : 16'hDEAD;
                chk("R5", 32'(result_w), 32'(e_res), "result_o");
                chk("R4", 32'(rises_obs), 32'(DB), "shift pulses in readout");
                chk("R7", 32'(since_sclk_fall), 32'(HO), "hold after last fall");
            end
            prev_conv = conv_w;
            prev_sclk = sclk_w;
        end
    end

    task automatic wait_valid();
        while (!valid_w) @(negedge clk);
    endtask

    // One transaction; poke: 0 none, 1 mid-busy start, 2 start on last busy cycle.
    task automatic txn(input logic [1:0] m, input int poke);
        @(negedge clk);
        start = 1'b1;
        mode  = m;
        @(negedge clk);
        start = 1'b0;
        mode  = ~m;
        if (poke == 1) begin
            repeat (60) @(negedge clk);
            start = 1'b1;                 // R8: ignored while busy
            @(negedge clk);
            start = 1'b0;
        end else if (poke == 2) begin
            repeat (LL - 2) @(negedge clk);
            chk("R8", 32'(busy_w), 32'd1, "busy on last busy cycle");
            start = 1'b1;                 // R8: lands on final busy cycle
            @(negedge clk);
            start = 1'b0;
        end
        wait_valid();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", 32'(conv_w), 32'd0, "conv_o in reset");
        chk("R1", 32'(sclk_w), 32'd0, "sclk_o in reset");
        chk("R1", 32'(cfg_w), 32'd0, "cfg_o in reset");
        chk("R1", 32'(busy_w), 32'd0, "busy_o in reset");
        chk("R1", 32'(valid_w), 32'd0, "valid_o in reset");
        chk("R1", 32'(result_w), 32'd0, "result_o in reset");
        rst_n = 1'b1;
        @(negedge clk);
        run_cmp = 1'b1;
        chk("R1", 32'(busy_w), 32'd0, "busy_o after reset");

        txn(2'b00, 0);
        txn(2'b01, 1);
        txn(2'b11, 2);
        txn(2'b10, 0);

        // Back-to-back: start held high, accepted on each valid cycle (R8).
        @(negedge clk);
        start = 1'b1;
        mode  = 2'b01;
        @(negedge clk);
        mode  = 2'b10;                    // latched mode must stay 01 (R6)
        wait_valid();
        mode  = 2'b00;
        @(negedge clk);
        mode  = 2'b11;
        wait_valid();
        mode  = 2'b11;
        @(negedge clk);
        start = 1'b0;
        wait_valid();

        txn(2'b10, 0);
        repeat (10) @(negedge clk);

        chk("R8", 32'(conv_rises), 32'd8, "conversions started");
        chk("R8", 32'(acc_cnt), 32'd8, "starts accepted by model");
        chk("R5", 32'(expq.size()), 32'd0, "results outstanding");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R2 watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule